// File: doc/BRIEF.md
# Tri-State Phase Detector with Lock Qualifier

This block compares two streams of single-cycle edge pulses, one from the divided reference and one from the divided oscillator, both sampled on a shared system clock. It drives a model of a three-state correction pin. The pin drives low when the reference edge leads, drives high when the oscillator edge leads, and is released when the two edges land together. The pin is modelled as a drive-enable bit and a data bit. One instance serves each synthesizer loop, for example one for receive and one for transmit.

Alongside the correction pin the block qualifies lock. It counts comparisons whose phase error is within a tolerance and reports lock on an active-low flag. A shared status pin carries one of three sources, chosen by a route field: an external carrier-detect level, the lock flag, or the raw reference pulse stream for test. The charge pump, the loop filter and the analog drivers sit outside this block.

Top module: `pfd_tristate_lock`

## Requirements
- R1: While reset is held and in the first cycle after it, pd_oe=0, pd_dat=0, lock_n=1 and status_o=0.
- R2: A reference pulse sampled alone while the pin is released gives pd_oe=1, pd_dat=0 (low drive) from the next cycle on. The pin is released (pd_oe=0) in the cycle after the edge that samples the next oscillator pulse. The drive therefore lasts exactly as many cycles as the two pulses are apart.
- R3: An oscillator pulse sampled alone while the pin is released gives pd_oe=1, pd_dat=1 (high drive) from the next cycle on, released the cycle after the next reference pulse.
- R4: Reference and oscillator pulses sampled in the same cycle while the pin is released leave it released (pd_oe=0, pd_dat=0).
- R5: Further pulses of the leading stream during a drive extend the same drive, so a faster reference holds the low level. A leading-stream pulse that arrives together with the closing pulse is absorbed, and the pin is released.
- R6: lock_n goes to 0 in the cycle after the LOCK_COUNT-th consecutive comparison whose error width is at most ERR_TOL cycles. A coincident comparison has width 0.
- R7: lock_n returns to 1 in the cycle after the edge at which a pending error first becomes certain to exceed ERR_TOL, or after a comparison closes wider than ERR_TOL. The good-comparison count restarts from zero.
- R8: status_o shows, one cycle later, cd_in when route_sel=00, lock_n when route_sel=01, and ref_pulse when route_sel[1]=1.
- R9: The error width counter saturates at MAX_ERR and never wraps, so a long error is never mistaken for a small one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Single-cycle divided reference edge |
| vco_pulse | input | 1 | Single-cycle divided oscillator edge |
| cd_in | input | 1 | Carrier-detect level for the status pin |
| route_sel | input | 2 | Status pin source select |
| pd_oe | output | 1 | Correction pin drive enable (0 = high impedance) |
| pd_dat | output | 1 | Correction pin level while driven (1 = high) |
| lock_n | output | 1 | Lock flag, 0 when locked |
| status_o | output | 1 | Routed status pin |

## Verification
The bench builds the block with LOCK_COUNT=4, ERR_TOL=1, MAX_ERR=7 and the registered status path. The small MAX_ERR lets a nine-cycle error run past the counter limit, where a wrapping counter would read back as a one-cycle error and finish a false lock three comparisons later. With ERR_TOL=1, a one-cycle offset counts as good, and any pending drive that survives a second edge drops lock before the late edge even arrives.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef enum logic [1:0] {
      RT_CARRIER = 2'b00,
      RT_LOCK    = 2'b01,
      RT_REFTAP  = 2'b10,
      RT_REFTAP2 = 2'b11
   } route_e;

   typedef enum logic [1:0] {
      LEAD_NONE = 2'b00,
      LEAD_REF  = 2'b01,
      LEAD_VCO  = 2'b10
   } lead_e;

endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core
   import pfd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ref_pulse,
   input  logic  vco_pulse,
   output lead_e lead_q,
   output logic  start_o,
   output logic  done_o
);

   lead_e lead_d;

   always_comb begin
      lead_d  = lead_q;
      start_o = 1'b0;
      done_o  = 1'b0;
      unique case (lead_q)
         LEAD_NONE: begin
            if (ref_pulse && vco_pulse) begin
               done_o = 1'b1;
            end else if (ref_pulse) begin
               lead_d  = LEAD_REF;
               start_o = 1'b1;
            end else if (vco_pulse) begin
               lead_d  = LEAD_VCO;
               start_o = 1'b1;
            end
         end
         LEAD_REF: begin
            if (vco_pulse) begin
               lead_d = LEAD_NONE;
               done_o = 1'b1;
            end
         end
         LEAD_VCO: begin
            if (ref_pulse) begin
               lead_d = LEAD_NONE;
               done_o = 1'b1;
            end
         end
         default: lead_d = LEAD_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lead_q <= LEAD_NONE;
      else        lead_q <= lead_d;
   end

endmodule

// File: rtl/pfd_err_meter.sv
module pfd_err_meter #(
   parameter int MAX_ERR = 63,
   parameter int ERR_TOL = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic start,
   input  logic done,
   output logic cmp_ok,
   output logic cmp_bad
);

   localparam int                CNT_W = $clog2(MAX_ERR + 1);
   localparam logic [CNT_W-1:0]  MAX_V = CNT_W'(MAX_ERR);
   localparam logic [CNT_W:0]    TOL_V = (CNT_W + 1)'(ERR_TOL);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W:0]   width_now, width_next;

   assign width_now  = active ? {1'b0, cnt_q} : '0;
   assign width_next = {1'b0, cnt_q} + 1'b1;

   always_comb begin
      cnt_d = '0;
      if (start)
         cnt_d = CNT_W'(1);
      else if (active && !done)
         cnt_d = (cnt_q == MAX_V) ? cnt_q : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cmp_ok  = done && (width_now <= TOL_V);
   assign cmp_bad = (done && (width_now > TOL_V)) ||
                    (active && !done && (width_next > TOL_V));

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
   parameter int LOCK_COUNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_ok,
   input  logic cmp_bad,
   output logic lock_n
);

   localparam int              GC_W = $clog2(LOCK_COUNT + 1);
   localparam logic [GC_W-1:0] LC_V = GC_W'(LOCK_COUNT);

   logic [GC_W-1:0] good_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         good_q <= '0;
      else if (cmp_bad)
         good_q <= '0;
      else if (cmp_ok && good_q != LC_V)
         good_q <= good_q + 1'b1;
   end

   assign lock_n = (good_q != LC_V);

endmodule

// File: rtl/pfd_status_route.sv
module pfd_status_route
   import pfd_pkg::*;
#(
   parameter bit STATUS_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] route_sel,
   input  logic       cd_in,
   input  logic       lock_n,
   input  logic       ref_tap,
   output logic       status_o
);

   logic sel_val;

   always_comb begin
      unique case (route_e'(route_sel))
         RT_CARRIER: sel_val = cd_in;
         RT_LOCK:    sel_val = lock_n;
         default:    sel_val = ref_tap;
      endcase
   end

   generate
      if (STATUS_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_o <= 1'b0;
            else        status_o <= sel_val;
         end
      end else begin : g_comb
         assign status_o = sel_val;
      end
   endgenerate

endmodule

// File: rtl/pfd_tristate_lock.sv
module pfd_tristate_lock
   import pfd_pkg::*;
#(
   parameter int LOCK_COUNT = 4,
   parameter int ERR_TOL    = 1,
   parameter int MAX_ERR    = 63,
   parameter bit STATUS_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_pulse,
   input  logic       vco_pulse,
   input  logic       cd_in,
   input  logic [1:0] route_sel,
   output logic       pd_oe,
   output logic       pd_dat,
   output logic       lock_n,
   output logic       status_o
);

   generate
      if (LOCK_COUNT < 1) begin : g_bad_lock_count
         $error("LOCK_COUNT must be at least 1");
      end
      if (ERR_TOL < 0) begin : g_bad_tol
         $error("ERR_TOL must not be negative");
      end
      if (MAX_ERR <= ERR_TOL) begin : g_bad_max
         $error("MAX_ERR must exceed ERR_TOL");
      end
   endgenerate

   lead_e lead_q;
   logic  start_w, done_w, ok_w, bad_w;

   pfd_edge_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pulse (ref_pulse),
      .vco_pulse (vco_pulse),
      .lead_q    (lead_q),
      .start_o   (start_w),
      .done_o    (done_w)
   );

   pfd_err_meter #(
      .MAX_ERR (MAX_ERR),
      .ERR_TOL (ERR_TOL)
   ) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (lead_q != LEAD_NONE),
      .start   (start_w),
      .done    (done_w),
      .cmp_ok  (ok_w),
      .cmp_bad (bad_w)
   );

   pfd_lock_qual #(
      .LOCK_COUNT (LOCK_COUNT)
   ) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_ok  (ok_w),
      .cmp_bad (bad_w),
      .lock_n  (lock_n)
   );

   pfd_status_route #(
      .STATUS_REG (STATUS_REG)
   ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .route_sel (route_sel),
      .cd_in     (cd_in),
      .lock_n    (lock_n),
      .ref_tap   (ref_pulse),
      .status_o  (status_o)
   );

   assign pd_oe  = (lead_q != LEAD_NONE);
   assign pd_dat = (lead_q == LEAD_VCO);

endmodule

// File: rtl/pfd_tristate_lock_chk.sv
module pfd_tristate_lock_chk #(
   parameter bit STATUS_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_pulse,
   input logic       vco_pulse,
   input logic       cd_in,
   input logic [1:0] route_sel,
   input logic       pd_oe,
   input logic       pd_dat,
   input logic       lock_n,
   input logic       status_o
);

   assert_ref_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse && !vco_pulse && !pd_oe) |=> (pd_oe && !pd_dat));

   assert_ref_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_oe && !pd_dat && vco_pulse) |=> !pd_oe);

   assert_vco_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vco_pulse && !ref_pulse && !pd_oe) |=> (pd_oe && pd_dat));

   assert_coincide_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse && vco_pulse && !pd_oe) |=> !pd_oe);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_oe && !pd_dat && !vco_pulse) |=> (pd_oe && !pd_dat));

   assert_lock_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_n) |-> $past(ref_pulse || vco_pulse));

   generate
      if (STATUS_REG) begin : g_reg_chk
         assert_route_cd_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (route_sel == 2'b00) |=> (status_o == $past(cd_in)));
         assert_route_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (route_sel == 2'b01) |=> (status_o == $past(lock_n)));
      end else begin : g_comb_chk
         assert_route_cd_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (route_sel == 2'b00) |-> (status_o == cd_in));
         assert_route_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (route_sel == 2'b01) |-> (status_o == lock_n));
      end
   endgenerate

endmodule

bind pfd_tristate_lock pfd_tristate_lock_chk #(.STATUS_REG(STATUS_REG)) u_chk (.*);

// File: tb/pfd_tristate_lock_tb_top.sv
module pfd_tristate_lock_tb_top;

   localparam int LC  = 4;
   localparam int TOL = 1;
   localparam int MAXE = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_p = 1'b0;
   logic       vco_p = 1'b0;
   logic       cd_in = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       pd_oe, pd_dat, lock_n, status_o;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    finished = 0;
   string cur_req = "R1";

   // behavioural reference state
   int pend   = 0;   // 0 none, 1 reference leads, 2 oscillator leads
   int pstart = 0;
   int cyc    = 0;
   int good   = 0;
   bit e_stat = 0;

   always #5 clk = ~clk;

   pfd_tristate_lock #(
      .LOCK_COUNT (LC),
      .ERR_TOL    (TOL),
      .MAX_ERR    (MAXE),
      .STATUS_REG (1'b1)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pulse (ref_p),
      .vco_pulse (vco_p),
      .cd_in     (cd_in),
      .route_sel (sel),
      .pd_oe     (pd_oe),
      .pd_dat    (pd_dat),
      .lock_n    (lock_n),
      .status_o  (status_o)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   function automatic bit exp_lock_n();
      return (good < LC);
   endfunction

   task automatic model(bit r, bit v);
      int w;
      bit done;
      // status pin samples its sources before the edge
      if (sel == 2'b00)      e_stat = cd_in;
      else if (sel == 2'b01) e_stat = exp_lock_n();
      else                   e_stat = r;
      done = 0;
      w = 0;
      if (pend == 0) begin
         if (r && v) begin done = 1; w = 0; end
         else if (r) begin pend = 1; pstart = cyc; end
         else if (v) begin pend = 2; pstart = cyc; end
      end else begin
         if ((pend == 1 && v) || (pend == 2 && r)) begin
            done = 1;
            w = cyc - pstart;
            pend = 0;
         end else if (cyc - pstart + 1 > TOL) begin
            good = 0;
         end
      end
      if (done) begin
         if (w <= TOL) begin
            if (good < LC) good++;
         end else begin
            good = 0;
         end
      end
      cyc++;
   endtask

   task automatic compare_all();
      chk(cur_req, "pd_oe",    pd_oe,    (pend != 0));
      chk(cur_req, "pd_dat",   pd_dat,   (pend == 2));
      chk(cur_req, "lock_n",   lock_n,   exp_lock_n());
      chk(cur_req, "status_o", status_o, e_stat);
   endtask

   task automatic step(bit r, bit v);
      ref_p = r;
      vco_p = v;
      @(posedge clk);
      model(r, v);
      @(negedge clk);
      ref_p = 1'b0;
      vco_p = 1'b0;
      compare_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, checked during and just after reset
      repeat (3) @(negedge clk);
      cur_req = "R1";
      compare_all();
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R2: reference leads by three cycles -> low drive of three cycles
      cur_req = "R2";
      cd_in = 1'b1;
      step(1, 0); idle(2); step(0, 1); idle(2);

      // R3: oscillator leads by two cycles -> high drive
      cur_req = "R3";
      cd_in = 1'b0;
      step(0, 1); step(0, 0); step(1, 0); idle(2);

      // R4: coincident edges keep the pin released
      cur_req = "R4";
      step(1, 1); idle(1); step(1, 1); idle(1);

      // R6: two more good comparisons (one width 0, one width 1) reach lock
      cur_req = "R6";
      step(1, 1); idle(1);
      step(1, 0); step(0, 1); idle(2);
      chk("R6", "lock_n after four good comparisons", lock_n, 1'b0);

      // R8: route the lock flag, the reference tap and the carrier input
      cur_req = "R8";
      sel = 2'b01; idle(2);
      sel = 2'b10; step(1, 1); idle(1); step(1, 1);
      sel = 2'b11; step(1, 0); step(0, 1); idle(1);
      sel = 2'b00; cd_in = 1'b1; idle(2); cd_in = 1'b0; idle(1);

      // R7: wide error drops lock before the late edge arrives
      cur_req = "R7";
      step(1, 1); idle(1);
      step(1, 0); step(0, 0);
      chk("R7", "lock_n after pending error exceeds tolerance", lock_n, 1'b1);
      step(0, 0); step(0, 1); idle(2);

      // R5: faster reference holds the low drive; absorbed pulse at close
      cur_req = "R5";
      step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 1); idle(1);
      step(0, 1); step(1, 1); idle(2);
      chk("R5", "pd_oe after absorbed pulse", pd_oe, 1'b0);

      // R9: nine-cycle error past the counter limit must not count as good
      cur_req = "R9";
      for (int i = 0; i < 4; i++) step(1, 1);
      chk("R9", "lock_n relocked before long error", lock_n, 1'b0);
      step(1, 0); idle(8); step(0, 1); idle(1);
      for (int i = 0; i < 3; i++) step(1, 1);
      chk("R9", "lock_n after long error and three good", lock_n, 1'b1);
      step(1, 1);
      chk("R9", "lock_n after fourth good", lock_n, 1'b0);

      // R5: mixed-rate pulse streams
      cur_req = "R5";
      sel = 2'b01;
      for (int i = 0; i < 240; i++) step((i % 5) == 0, (i % 7) == 3);
      cur_req = "R6";
      for (int i = 0; i < 60; i++) step((i % 6) == 0, (i % 6) == ((i / 12) % 2));

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule